// File: doc/BRIEF.md
# Slave-Mode Line and Field Timing Counter

This block rebuilds line and field timing for a standard-definition video encoder that takes its sync from an outside source. It counts lines on the rising edges of the incoming horizontal sync. It marks each field start with a one-cycle pulse and tracks which of the two interlaced fields is current. It also reports when its timing outputs can be trusted. After reset it waits for the first vertical sync rising edge and locks to it. The outputs stay blanked until one whole field has been seen.

Tape sources in fast forward or rewind produce fields that are shorter or longer than the nominal line total. In the conventional behaviour the counter wraps at the nominal total, and any vertical sync that arrives at another time adds a second field start. When the resync control is set and the slave mode is not mode 0, the counter follows the incoming vertical sync instead. An early vertical sync restarts the count at line 1. A late one finds the counter parked on the last line, so no extra field start appears. In slave mode 0 the resync control is ignored.

Top module: `sd_field_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the block; in the cycle after reset `line_cnt` is 0, `field_id` is 0, `sof_pulse` is 0 and `timing_valid` is 0.
- R2: After reset, HSYNC edges are ignored until the first VSYNC rising edge. That edge loads the internal line count with 1 and produces no field start. A rising edge is a sample of 1 that follows a sample of 0.
- R3: While locked, each HSYNC rising edge advances the line count by one.
- R4: With resync inactive, an HSYNC rising edge while the line count equals `LINES_PER_FIELD` wraps the count to 1 and produces a field start.
- R5: With resync inactive, a VSYNC rising edge while locked produces a field start and leaves the line count unchanged (the duplicate field start).
- R6: With resync active (`resync_en`=1 and `slave_mode` not 0), a VSYNC rising edge reloads the line count with 1 and produces a field start, even before the line total is reached.
- R7: With resync active, an HSYNC rising edge at the line total holds the count at the total and produces no field start.
- R8: In slave mode 0 (`slave_mode`=0) `resync_en` has no effect: wrap and VSYNC behave as in R4 and R5.
- R9: Each field start drives `sof_pulse` high for exactly the cycle after the clock edge that saw the sync edge and toggles `field_id`. The first field start after reset sets it to 1.
- R10: `timing_valid` rises together with the first field start after lock and stays high until reset. While it is low, `line_cnt` and `field_id` read 0 and `sof_pulse` stays low.
- R11: When HSYNC and VSYNC rise on the same clock, a single field start is produced. With resync active the count goes to 1. With resync inactive the HSYNC advance applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Incoming horizontal sync, active high |
| vsync_in | input | 1 | Incoming vertical sync, active high |
| slave_mode | input | MODE_W | Slave timing mode select; 0 disables resync |
| resync_en | input | 1 | Follow incoming VSYNC for field timing |
| line_cnt | output | LINE_W | Current line, 1..LINES_PER_FIELD; 0 while not valid |
| field_id | output | 1 | Current field of the pair; 0 while not valid |
| sof_pulse | output | 1 | One-cycle start-of-field pulse |
| timing_valid | output | 1 | Timing outputs are trustworthy |

## Verification
The assertions assume that `slave_mode` and `resync_en` stay constant between resets. They also assume that each sync input is sampled low at least once between two of its rising edges, so that every edge is seen as a single event. The stimulus changes the mode controls only while reset is held. It drives each sync high for one cycle and then holds it low for at least two cycles. Early, late and simultaneous sync arrivals are produced within these limits.

// File: rtl/sd_field_timer_pkg.sv
package sd_field_timer_pkg;

    typedef enum logic [0:0] {
        LOCK_WAIT = 1'b0,
        LOCK_RUN  = 1'b1
    } lock_state_t;

    typedef struct packed {
        logic h_rise;
        logic v_rise;
    } sync_events_t;

    typedef struct packed {
        logic field;
        logic valid;
        logic sof;
    } field_state_t;

    localparam int SYNC_COUNT = 2;
    localparam int SYNC_H_BIT = 1;
    localparam int SYNC_V_BIT = 0;

    function automatic logic follow_vsync(input logic [7:0] mode, input logic enable);
        return enable && (mode != 8'd0);
    endfunction

endpackage

// File: rtl/sd_sync_rise.sv
module sd_sync_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= din;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = din[i] & ~prev_q[i];
    end
endmodule

// File: rtl/sd_line_tracker.sv
module sd_line_tracker
    import sd_field_timer_pkg::*;
#(
    parameter int LINES_PER_FIELD = 262,
    parameter int LINE_W          = $clog2(LINES_PER_FIELD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  sync_events_t      ev,
    input  logic              resync_on,
    output logic [LINE_W-1:0] line_q,
    output logic              locked,
    output logic              field_start
);
    localparam logic [LINE_W-1:0] LAST  = LINE_W'(LINES_PER_FIELD);
    localparam logic [LINE_W-1:0] FIRST = LINE_W'(1);

    lock_state_t       st_q, st_d;
    logic [LINE_W-1:0] line_d;

    always_comb begin
        st_d        = st_q;
        line_d      = line_q;
        field_start = 1'b0;
        case (st_q)
            LOCK_WAIT: begin
                if (ev.v_rise) begin
                    st_d   = LOCK_RUN;
                    line_d = FIRST;
                end
            end
            default: begin
                if (resync_on) begin
                    if (ev.v_rise) begin
                        line_d      = FIRST;
                        field_start = 1'b1;
                    end else if (ev.h_rise && line_q != LAST) begin
                        line_d = line_q + FIRST;
                    end
                end else begin
                    if (ev.h_rise) begin
                        if (line_q == LAST) begin
                            line_d      = FIRST;
                            field_start = 1'b1;
                        end else begin
                            line_d = line_q + FIRST;
                        end
                    end
                    if (ev.v_rise) field_start = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LOCK_WAIT;
            line_q <= '0;
        end else begin
            st_q   <= st_d;
            line_q <= line_d;
        end
    end

    assign locked = (st_q == LOCK_RUN);

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        locked |-> (line_q >= FIRST && line_q <= LAST)) else $error("line out of range"); // R3
    AST_VSYNC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (locked && resync_on && ev.v_rise) |=> (line_q == FIRST)) else $error("no reload"); // R6
    AST_HOLD_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        (locked && resync_on && ev.h_rise && !ev.v_rise && line_q == LAST) |=> $stable(line_q))
        else $error("no hold at last line"); // R7
    AST_DUP_KEEPS_LINE: assert property (@(posedge clk) disable iff (rst)
        (locked && !resync_on && ev.v_rise && !ev.h_rise) |=> $stable(line_q))
        else $error("vsync moved line"); // R5
    AST_WAIT_IGNORES_H: assert property (@(posedge clk) disable iff (rst)
        (!locked && !ev.v_rise) |=> (line_q == '0)) else $error("counted before lock"); // R2
endmodule

// File: rtl/sd_field_flag.sv
module sd_field_flag
    import sd_field_timer_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         field_start,
    output field_state_t fs_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= '0;
        end else begin
            fs_q.sof <= field_start;
            if (field_start) begin
                fs_q.field <= ~fs_q.field;
                fs_q.valid <= 1'b1;
            end
        end
    end

    AST_FIELD_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        field_start |=> (fs_q.field != $past(fs_q.field))) else $error("field not toggled"); // R9
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        fs_q.valid |=> fs_q.valid) else $error("valid dropped"); // R10
endmodule

// File: rtl/sd_field_timer.sv
module sd_field_timer
    import sd_field_timer_pkg::*;
#(
    parameter int LINES_PER_FIELD = 262,
    parameter int MODE_W          = 2,
    parameter int LINE_W          = $clog2(LINES_PER_FIELD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic [MODE_W-1:0] slave_mode,
    input  logic              resync_en,
    output logic [LINE_W-1:0] line_cnt,
    output logic              field_id,
    output logic              sof_pulse,
    output logic              timing_valid
);
    logic [SYNC_COUNT-1:0] sync_bus;
    logic [SYNC_COUNT-1:0] rise_bus;
    sync_events_t          ev;
    logic                  resync_on;
    logic [LINE_W-1:0]     line_q;
    logic                  locked;
    logic                  field_start;
    field_state_t          fs_q;

    assign sync_bus[SYNC_H_BIT] = hsync_in;
    assign sync_bus[SYNC_V_BIT] = vsync_in;
    assign ev.h_rise = rise_bus[SYNC_H_BIT];
    assign ev.v_rise = rise_bus[SYNC_V_BIT];
    assign resync_on = follow_vsync(8'(slave_mode), resync_en);

    sd_sync_rise #(.N(SYNC_COUNT)) u_rise (
        .clk (clk),
        .rst (rst),
        .din (sync_bus),
        .rise(rise_bus)
    );

    sd_line_tracker #(.LINES_PER_FIELD(LINES_PER_FIELD), .LINE_W(LINE_W)) u_lines (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .resync_on  (resync_on),
        .line_q     (line_q),
        .locked     (locked),
        .field_start(field_start)
    );

    sd_field_flag u_field (
        .clk        (clk),
        .rst        (rst),
        .field_start(field_start),
        .fs_q       (fs_q)
    );

    assign timing_valid = fs_q.valid;
    assign sof_pulse    = fs_q.sof;
    assign field_id     = fs_q.valid ? fs_q.field : 1'b0;
    assign line_cnt     = fs_q.valid ? line_q : '0;

    AST_SOF_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> locked) else $error("sof before lock"); // R10
    AST_MODE0_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (locked && slave_mode == '0 && ev.v_rise && !ev.h_rise) |=> $stable(line_q))
        else $error("mode 0 followed vsync"); // R8
    AST_VALID_AFTER_SOF: assert property (@(posedge clk) disable iff (rst)
        sof_pulse |-> timing_valid) else $error("sof without valid"); // R9
endmodule

// File: tb/sd_field_timer_tb.sv
module sd_field_timer_tb;
    localparam int TOTAL  = 5;
    localparam int LINE_W = $clog2(TOTAL + 1);
    localparam int NVEC   = 20;
    // vector: op[8:7] (1=H,2=V,3=both) | line[6:3] | field[2] | sof[1] | valid[0]
    localparam logic [8:0] VEC [NVEC] = '{
        {2'd1, 4'd0, 1'b0, 1'b0, 1'b0},  // R2 H before lock ignored
        {2'd2, 4'd0, 1'b0, 1'b0, 1'b0},  // R2 lock, no sof
        {2'd1, 4'd0, 1'b0, 1'b0, 1'b0},
        {2'd1, 4'd0, 1'b0, 1'b0, 1'b0},
        {2'd1, 4'd0, 1'b0, 1'b0, 1'b0},
        {2'd1, 4'd0, 1'b0, 1'b0, 1'b0},
        {2'd2, 4'd1, 1'b1, 1'b1, 1'b1},  // R10 first field start
        {2'd1, 4'd2, 1'b1, 1'b0, 1'b1},  // R3
        {2'd1, 4'd3, 1'b1, 1'b0, 1'b1},
        {2'd2, 4'd1, 1'b0, 1'b1, 1'b1},  // R6 early vsync
        {2'd1, 4'd2, 1'b0, 1'b0, 1'b1},
        {2'd1, 4'd3, 1'b0, 1'b0, 1'b1},
        {2'd1, 4'd4, 1'b0, 1'b0, 1'b1},
        {2'd1, 4'd5, 1'b0, 1'b0, 1'b1},
        {2'd1, 4'd5, 1'b0, 1'b0, 1'b1},  // R7 hold
        {2'd1, 4'd5, 1'b0, 1'b0, 1'b1},  // R7 hold
        {2'd2, 4'd1, 1'b1, 1'b1, 1'b1},  // R6 late vsync
        {2'd3, 4'd1, 1'b0, 1'b1, 1'b1},  // R11 both
        {2'd1, 4'd2, 1'b0, 1'b0, 1'b1},
        {2'd1, 4'd3, 1'b0, 1'b0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hsync_in = 1'b0;
    logic              vsync_in = 1'b0;
    logic [1:0]        slave_mode = 2'd1;
    logic              resync_en = 1'b1;
    logic [LINE_W-1:0] line_cnt;
    logic              field_id;
    logic              sof_pulse;
    logic              timing_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sd_field_timer #(.LINES_PER_FIELD(TOTAL), .MODE_W(2)) u_dut (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .slave_mode(slave_mode), .resync_en(resync_en), .line_cnt(line_cnt),
        .field_id(field_id), .sof_pulse(sof_pulse), .timing_valid(timing_valid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_all(input string req, input int ln, input int fd, input int sf, input int vl);
        chk(req, "line_cnt", int'(line_cnt), ln);
        chk(req, "field_id", int'(field_id), fd);
        chk(req, "sof_pulse", int'(sof_pulse), sf);
        chk(req, "timing_valid", int'(timing_valid), vl);
    endtask

    task automatic do_reset(input logic [1:0] mode, input logic en);
        @(negedge clk);
        rst = 1'b1; hsync_in = 1'b0; vsync_in = 1'b0;
        slave_mode = mode; resync_en = en;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive op for one cycle, sample the cycle after the edge, then idle two cycles
    task automatic step(input logic [1:0] op);
        @(negedge clk);
        hsync_in = op[0];
        vsync_in = op[1];
        @(negedge clk);
    endtask

    task automatic idle();
        hsync_in = 1'b0;
        vsync_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R1 reset state
        do_reset(2'd1, 1'b1);
        @(negedge clk);
        expect_all("R1", 0, 0, 0, 0);

        // table walk: resync active, mode 1
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][8:7]);
            expect_all($sformatf("R3/R6/R7 vec%0d", i), int'(VEC[i][6:3]),
                       int'(VEC[i][2]), int'(VEC[i][1]), int'(VEC[i][0]));
            idle();
            chk("R9", "sof_pulse after idle", int'(sof_pulse), 0);
        end

        // resync inactive: wrap and duplicate field start
        do_reset(2'd1, 1'b0);
        step(2'd2); idle();
        for (int k = 0; k < TOTAL - 1; k++) begin step(2'd1); idle(); end
        step(2'd1);
        expect_all("R4", 1, 1, 1, 1);
        idle();
        step(2'd1); idle();
        step(2'd1);
        chk("R3", "line_cnt", int'(line_cnt), 3);
        idle();
        step(2'd2);
        expect_all("R5", 3, 0, 1, 1);
        idle();
        step(2'd3);
        expect_all("R11", 4, 1, 1, 1);
        idle();

        // slave mode 0 ignores resync enable
        do_reset(2'd0, 1'b1);
        step(2'd2); idle();
        for (int k = 0; k < TOTAL - 1; k++) begin step(2'd1); idle(); end
        step(2'd1);
        expect_all("R8 wrap", 1, 1, 1, 1);
        idle();
        step(2'd1); idle();
        step(2'd2);
        expect_all("R8 vsync", 2, 0, 1, 1);
        idle();

        // reset mid-run, then HSYNC before lock is ignored
        do_reset(2'd1, 1'b1);
        @(negedge clk);
        expect_all("R1 mid-run", 0, 0, 0, 0);
        step(2'd1); idle();
        step(2'd2); idle();
        step(2'd1); idle();
        step(2'd2);
        expect_all("R2", 1, 1, 1, 1);
        idle();
        step(2'd1);
        chk("R2", "line after lock+1 H", int'(line_cnt), 2);
        idle();

        finish_run();
    end
endmodule